// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This unit watches sixteen external interrupt lines. Each line picks pin n of one of several GPIO ports through its own port-select field. The selected level passes through a two-flop synchronizer. The unit then compares it with its previous sample to find rising and falling transitions. A per-line enable gates each edge direction, so a line can trigger on rising edges, falling edges, both, or neither. An enabled edge sets a pending flag for that line. The flag stays set until software writes 1 to it.

Requests go to a downstream vectored interrupt controller on three shared wires. One wire covers lines 0 and 1, one covers lines 2 and 3, and one covers lines 4 to 15. A wire is high while any line in its group is both pending and unmasked. Software configures the unit and reads it back through a small word-wide register port. Reads return their data one cycle after the address is presented.

Top module: `eiu_top`

## Requirements
- R1: After a synchronous active-high reset, every select field, rise enable, fall enable, mask bit and pending bit reads 0, and all three request outputs are low.
- R2: When a line's rise-enable bit (address 4, bit n) is 1, a 0-to-1 transition of its selected pin sets pending bit n (address 7).
- R3: A 1-to-0 transition sets pending bit n only when fall-enable bit n (address 5) is 1. With both enables set, both directions set the flag. With neither set, no transition sets it.
- R4: Line n follows bit p*16+n of `port_pins`, where p is the 4-bit select field of line n. That field sits at address n/4, bits [4*(n%4)+3 : 4*(n%4)]. A select value of 4 or more connects the line to constant 0, and pins on unselected ports have no effect.
- R5: Writing address 7 clears every pending bit whose data bit is 1. Bits written with 0 keep their value.
- R6: If an enabled edge on a line is detected in the same cycle that a write of 1 clears that line's pending bit, the bit stays set.
- R7: `irq_grp[0]` covers lines 0-1, `irq_grp[1]` covers lines 2-3 and `irq_grp[2]` covers lines 4-15. Each output is registered and is high exactly when, one cycle earlier, some line in its group had both its pending bit and its mask bit (address 6) set.
- R8: A line whose mask bit is 0 still records its pending bit but drives no request. Setting the mask bit later raises the group's request.
- R9: `rd_data` shows the register at `rd_addr` one clock after the address is applied, and all registers read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | 64 | Pin levels, port p pin n at bit p*16+n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| irq_grp | output | 3 | Grouped interrupt requests |

## Verification
A stuck or wrongly set pending bit shows up at the ports in two ways. It appears on the pending register one read later. It also appears on the group request one cycle after the flag changes, unless that line is masked. A select field that points at the wrong port shows up as a missing or spurious pending bit about three cycles after the bench toggles a pin. The set-beats-clear rule is checked by placing the clearing write exactly on the cycle when the synchronized edge is detected. A loss of the flag there is then visible on the very next read.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL0 = 3'd0,
    A_SEL1 = 3'd1,
    A_SEL2 = 3'd2,
    A_SEL3 = 3'd3,
    A_RISE = 3'd4,
    A_FALL = 3'd5,
    A_MASK = 3'd6,
    A_PEND = 3'd7
  } eiu_addr_e;
endpackage

// File: rtl/eiu_line_sync.sv
module eiu_line_sync #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pins,
  input  logic [SEL_W-1:0]     sel,
  output logic                 rose,
  output logic                 fell
);
  logic chosen;
  logic s1_q, s2_q, prev_q;

  // Port multiplexer; out-of-range selections read as 0
  always_comb begin
    chosen = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel == SEL_W'(p)) chosen = pins[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= chosen;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rose = s2_q & ~prev_q;
  assign fell = ~s2_q & prev_q;
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
  import eiu_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [NUM_LINES-1:0]       wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_LINES-1:0]       edge_hit,
  output logic [NUM_LINES*SEL_W-1:0] sel_flat,
  output logic [NUM_LINES-1:0]       rise_en,
  output logic [NUM_LINES-1:0]       fall_en,
  output logic [NUM_LINES-1:0]       mask,
  output logic [NUM_LINES-1:0]       pend,
  output logic [NUM_LINES-1:0]       rd_data
);
  localparam int DATA_W   = NUM_LINES;
  localparam int SEL_REGS = (NUM_LINES * SEL_W) / DATA_W;

  logic [DATA_W-1:0] sel_q [SEL_REGS];
  logic [DATA_W-1:0] rise_q, fall_q, mask_q, pend_q, rd_q, rd_d, clr;

  assign clr = (wr_en && (wr_addr == A_PEND)) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEL_REGS; i++) sel_q[i] <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en) begin
        case (eiu_addr_e'(wr_addr))
          A_RISE: rise_q <= wr_data;
          A_FALL: fall_q <= wr_data;
          A_MASK: mask_q <= wr_data;
          A_PEND: ;
          default: begin
            for (int i = 0; i < SEL_REGS; i++)
              if (wr_addr == ADDR_W'(i)) sel_q[i] <= wr_data;
          end
        endcase
      end
      // new edge takes priority over a simultaneous clear
      pend_q <= (pend_q & ~clr) | edge_hit;
    end
  end

  always_comb begin
    rd_d = '0;
    case (eiu_addr_e'(rd_addr))
      A_RISE: rd_d = rise_q;
      A_FALL: rd_d = fall_q;
      A_MASK: rd_d = mask_q;
      A_PEND: rd_d = pend_q;
      default: begin
        for (int i = 0; i < SEL_REGS; i++)
          if (rd_addr == ADDR_W'(i)) rd_d = sel_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  genvar g;
  generate
    for (g = 0; g < SEL_REGS; g++) begin : g_sel
      assign sel_flat[g*DATA_W +: DATA_W] = sel_q[g];
    end
  endgenerate

  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign mask    = mask_q;
  assign pend    = pend_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/eiu_irq_merge.sv
module eiu_irq_merge #(
  parameter int NUM_LINES = 16,
  parameter int G0_HI     = 1,
  parameter int G1_HI     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] mask,
  output logic [2:0]           irq
);
  logic [NUM_LINES-1:0] active;
  logic [2:0]           irq_d, irq_q;

  assign active   = pend & mask;
  assign irq_d[0] = |active[G0_HI:0];
  assign irq_d[1] = |active[G1_HI:G0_HI+1];
  assign irq_d[2] = |active[NUM_LINES-1:G1_HI+1];

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/eiu_top.sv
module eiu_top
  import eiu_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4,
  parameter int G0_HI     = 1,
  parameter int G1_HI     = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           wr_en,
  input  logic [2:0]                     wr_addr,
  input  logic [NUM_LINES-1:0]           wr_data,
  input  logic [2:0]                     rd_addr,
  output logic [NUM_LINES-1:0]           rd_data,
  output logic [2:0]                     irq_grp
);
  logic [NUM_LINES*SEL_W-1:0] sel_flat;
  logic [NUM_LINES-1:0] rise_en, fall_en, mask_q, pend_q;
  logic [NUM_LINES-1:0] rose, fell, edge_hit;

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_line
      logic [NUM_PORTS-1:0] line_pins;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pin
        assign line_pins[p] = port_pins[p*NUM_LINES + n];
      end
      eiu_line_sync #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins (line_pins),
        .sel  (sel_flat[n*SEL_W +: SEL_W]),
        .rose (rose[n]),
        .fell (fell[n])
      );
    end
  endgenerate

  assign edge_hit = (rose & rise_en) | (fell & fall_en);

  eiu_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .edge_hit (edge_hit),
    .sel_flat (sel_flat),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .mask     (mask_q),
    .pend     (pend_q),
    .rd_data  (rd_data)
  );

  eiu_irq_merge #(.NUM_LINES(NUM_LINES), .G0_HI(G0_HI), .G1_HI(G1_HI)) u_merge (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_q),
    .mask (mask_q),
    .irq  (irq_grp)
  );
endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
  parameter int NUM_LINES = 16,
  parameter int G0_HI     = 1,
  parameter int G1_HI     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [2:0]           wr_addr,
  input logic [NUM_LINES-1:0] wr_data,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] mask,
  input logic [2:0]           irq_grp
);
  logic [NUM_LINES-1:0] pm;
  assign pm = pend & mask;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (irq_grp == 3'b000 && pend == '0)); // R1

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|edge_hit) |=> ((pend & $past(edge_hit)) == $past(edge_hit))); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(edge_hit)) == '0)); // R3

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd7) |=>
      ((pend & $past(wr_data) & ~$past(edge_hit)) == '0)); // R5

  AST_IRQ_GROUPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_grp == {|$past(pm[NUM_LINES-1:G1_HI+1]),
                          |$past(pm[G1_HI:G0_HI+1]),
                          |$past(pm[G0_HI:0])})); // R7
endmodule

bind eiu_top eiu_checker #(.NUM_LINES(NUM_LINES), .G0_HI(G0_HI), .G1_HI(G1_HI)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .edge_hit (edge_hit),
  .pend     (pend_q),
  .mask     (mask_q),
  .irq_grp  (irq_grp)
);

// File: tb/sim_eiu_top.sv
`timescale 1ns/1ps
module sim_eiu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  irq_grp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eiu_top u0 (
    .clk(clk), .rst(rst), .port_pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_grp(irq_grp)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pin(input int port, input int line, input logic v);
    @(negedge clk);
    pins[port*16 + line] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d, 16'h0, $sformatf("R1 reg %0d after reset", a));
    end
    chk({13'h0, irq_grp}, 16'h0, "R1 irq after reset");
  endtask

  task automatic t_rise();
    logic [15:0] d;
    wr(3'd6, 16'h0001);
    wr(3'd4, 16'h0001);
    pin(0, 0, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0001, "R2 rise sets pending line0");
    chk({13'h0, irq_grp}, 16'h0001, "R7 group0 request line0");
    wr(3'd7, 16'h0001);
    repeat (2) @(negedge clk);
    rd(3'd7, d);
    chk(d, 16'h0000, "R5 write1 clears line0");
    chk({13'h0, irq_grp}, 16'h0, "R7 request drops after clear");
    pin(0, 0, 1'b0);
    rd(3'd7, d);
    chk(d, 16'h0000, "R3 fall ignored without fall enable");
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_fall_both();
    logic [15:0] d;
    wr(3'd5, 16'h0020);
    pin(0, 5, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0000, "R3 rise ignored when only fall enabled");
    pin(0, 5, 1'b0);
    rd(3'd7, d);
    chk(d, 16'h0020, "R3 fall sets pending line5");
    wr(3'd7, 16'h0020);
    wr(3'd4, 16'h0008);
    wr(3'd5, 16'h0008);
    pin(0, 3, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0008, "R3 both: rise sets line3");
    wr(3'd7, 16'h0008);
    pin(0, 3, 1'b0);
    rd(3'd7, d);
    chk(d, 16'h0008, "R3 both: fall sets line3");
    wr(3'd7, 16'h0008);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0000);
    pin(0, 7, 1'b1);
    pin(0, 7, 1'b0);
    rd(3'd7, d);
    chk(d, 16'h0000, "R3 no enable no pending");
  endtask

  task automatic t_w0();
    logic [15:0] d;
    wr(3'd4, 16'h0204);
    pin(0, 2, 1'b1);
    pin(0, 9, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0204, "R2 lines 2 and 9 pending");
    wr(3'd7, 16'h0000);
    rd(3'd7, d);
    chk(d, 16'h0204, "R5 write0 keeps pending");
    wr(3'd7, 16'h0200);
    rd(3'd7, d);
    chk(d, 16'h0004, "R5 clear only line9");
    wr(3'd7, 16'h0004);
    wr(3'd4, 16'h0000);
    pin(0, 2, 1'b0);
    pin(0, 9, 1'b0);
  endtask

  task automatic t_sel();
    logic [15:0] d;
    wr(3'd1, 16'h0200);
    rd(3'd1, d);
    chk(d, 16'h0200, "R9 select register readback");
    wr(3'd4, 16'h0040);
    pin(0, 6, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0000, "R4 unselected port0 ignored");
    pin(0, 6, 1'b0);
    pin(2, 6, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0040, "R4 port2 pin6 drives line6");
    pin(2, 6, 1'b0);
    wr(3'd7, 16'h0040);
    wr(3'd1, 16'h0900);
    pin(2, 6, 1'b1);
    pin(3, 6, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0000, "R4 out-of-range select reads 0");
    pin(2, 6, 1'b0);
    pin(3, 6, 1'b0);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd6, 16'h0000);
    wr(3'd4, 16'h1004);
    pin(0, 12, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h1000, "R8 masked line still pends");
    chk({13'h0, irq_grp}, 16'h0, "R8 masked line no request");
    wr(3'd6, 16'h1000);
    @(negedge clk);
    chk({13'h0, irq_grp}, 16'h0004, "R8 unmask raises group2");
    wr(3'd6, 16'h1004);
    pin(0, 2, 1'b1);
    chk({13'h0, irq_grp}, 16'h0006, "R7 line2 raises group1");
    wr(3'd7, 16'h1004);
    repeat (2) @(negedge clk);
    chk({13'h0, irq_grp}, 16'h0, "R7 all groups low after clear");
    pin(0, 12, 1'b0);
    pin(0, 2, 1'b0);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    wr(3'd4, 16'h0002);
    wr(3'd5, 16'h0002);
    pin(0, 1, 1'b1);
    rd(3'd7, d);
    chk(d, 16'h0002, "R6 setup pending line1");
    @(negedge clk);
    pins[1] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h0002;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd7, d);
    chk(d, 16'h0002, "R6 edge beats same-cycle clear");
    wr(3'd7, 16'h0002);
    rd(3'd7, d);
    chk(d, 16'h0000, "R5 later clear succeeds");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rise();
    t_fall_both();
    t_w0();
    t_sel();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule